// File: doc/BRIEF.md
# Permanent Sector Lockdown Unit

This block decodes a serial lockdown command arriving over a four-wire SPI link (mode 0, chip select active low) and permanently marks one flash sector as read-only. A command is a four-byte key followed by a 24-bit address. Any address that falls inside a sector selects that whole sector. The sector index comes from a parameterised slice of the address.

When chip select is released after exactly seven whole bytes, the block runs a self-timed lockdown cycle of a parameterised length and reports busy for all of it. It then sets that sector's lock bit. Lock bits are sticky: no serial command and no ordinary reset can clear them. Only a separate power-on clear input, which exists to model a fresh device in simulation, returns them to zero.

The erase and program paths use two outputs. The whole lock vector is available to them. A combinational permit flag also reports whether an address they present lies in an unlocked sector.

The SPI pins are sampled in the system clock domain through synchronisers, so the serial clock must be slower than about a quarter of the system clock.

Top module: `lockdown_unit`

## Requirements
- R1: A command is accepted only when the first four bytes after chip select falls are 3DH, 2AH, 7FH, 30H, in that order. Each byte is shifted in MSB first on the rising edge of the serial clock. Any other value in any of those four positions leaves busy low and every lock bit unchanged.
- R2: Bytes five to seven form a 24-bit address, MSB first. The target sector is address bits [21:16]. Bits [23:22] and [15:0] do not change which sector is locked.
- R3: A command whose frame holds other than exactly 56 serial clock pulses between chip select falling and rising is discarded. This covers a frame that is short by one bit, long by one bit, or a whole byte long. No busy period follows and no lock bit changes.
- R4: After an accepted command, busy rises within 8 system clock cycles of chip select rising. It then stays high for exactly TP_CYCLES system clock cycles.
- R5: The lock bit is set one cycle after busy falls. It does not change while busy is high.
- R6: No command and no assertion of rst clears a lock bit. Asserting pwr_on_clr clears all of them.
- R7: Locking one sector leaves every other sector's lock bit as it was. Locking an already locked sector keeps it locked.
- R8: write_permit is 0 when the sector of chk_addr (bits [21:16]) is locked, and 1 otherwise. It responds combinationally to chk_addr.
- R9: Serial traffic while busy is high, including a complete valid lockdown command, is ignored. It starts no second busy period and sets no lock bit.
- R10: Asserting rst during busy ends the busy period. The pending lock bit is left unset.
- R11: Directly after reset, busy is 0. After a power-on clear, lock_vec is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the command logic; lock bits are kept |
| pwr_on_clr | input | 1 | Power-on model input that clears every lock bit |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in, MSB first |
| busy | output | 1 | High during the self-timed lockdown cycle |
| lock_vec | output | 64 | One sticky lock bit per sector |
| chk_addr | input | 24 | Erase or program address to be checked |
| write_permit | output | 1 | 1 when chk_addr lies in an unlocked sector |

## Verification
Valid commands are sent at addresses with the high and low address bits set, so a wrong slice of the address shows up as the wrong bit in the lock vector. Each key byte is corrupted on its own, and frames are sent one bit short, one bit long and a byte long. These separate a decoder that compares the full key and counts bits from one that counts only bytes or checks only part of the key. A full valid command sent during busy, and a reset in the middle of busy, each show whether the lock bit is tied to the end of the timed cycle rather than to chip select. Random addresses, keys and frame lengths then give the sticky vector and the permit flag a varied history.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_BUSY} lkd_state_e;

  localparam logic [31:0] LOCK_KEY  = 32'h3D2A7F30;
  localparam int          KEY_BYTES = 4;
  localparam int          CMD_BYTES = 7;

  function automatic logic [7:0] key_byte(input logic [3:0] idx);
    logic [31:0] sh;
    sh = LOCK_KEY >> (8 * (KEY_BYTES - 1 - int'(idx)));
    return sh[7:0];
  endfunction
endpackage

// File: rtl/lkd_spi_front.sv
module lkd_spi_front #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       byte_vld,
  output logic [7:0] byte_o,
  output logic       cs_fall,
  output logic       cs_rise,
  output logic       partial
);
  logic [SYNC-1:0] sck_sh, cs_sh, mosi_sh;
  logic sck_s, cs_s, mosi_s, sck_d, cs_d;
  logic [2:0] bit_q;
  logic [7:0] sh_q;
  logic byte_vld_q, cs_fall_q, cs_rise_q, partial_q;

  assign sck_s  = sck_sh[SYNC-1];
  assign cs_s   = cs_sh[SYNC-1];
  assign mosi_s = mosi_sh[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sh     <= '0;
      cs_sh      <= '1;
      mosi_sh    <= '0;
      sck_d      <= 1'b0;
      cs_d       <= 1'b1;
      bit_q      <= '0;
      sh_q       <= '0;
      byte_vld_q <= 1'b0;
      cs_fall_q  <= 1'b0;
      cs_rise_q  <= 1'b0;
      partial_q  <= 1'b0;
    end else begin
      sck_sh     <= {sck_sh[SYNC-2:0], spi_sck};
      cs_sh      <= {cs_sh[SYNC-2:0], spi_cs_n};
      mosi_sh    <= {mosi_sh[SYNC-2:0], spi_mosi};
      sck_d      <= sck_s;
      cs_d       <= cs_s;
      cs_fall_q  <= cs_d & ~cs_s;
      cs_rise_q  <= ~cs_d & cs_s;
      byte_vld_q <= 1'b0;
      if (~cs_d & cs_s) partial_q <= (bit_q != 3'd0);
      if (cs_s) begin
        bit_q <= '0;
      end else if (sck_s & ~sck_d) begin
        sh_q  <= {sh_q[6:0], mosi_s};
        bit_q <= bit_q + 3'd1;
        if (bit_q == 3'd7) byte_vld_q <= 1'b1;
      end
    end
  end

  assign byte_vld = byte_vld_q;
  assign byte_o   = sh_q;
  assign cs_fall  = cs_fall_q;
  assign cs_rise  = cs_rise_q;
  assign partial  = partial_q;
endmodule

// File: rtl/lkd_cmd_fsm.sv
module lkd_cmd_fsm
  import lkd_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int SEC_LSB   = 16,
  parameter int SEC_BITS  = 6,
  parameter int TP_CYCLES = 1000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                byte_vld,
  input  logic [7:0]          byte_i,
  input  logic                cs_fall,
  input  logic                cs_rise,
  input  logic                partial,
  output logic                busy,
  output logic                lock_set,
  output logic [SEC_BITS-1:0] lock_sec
);
  localparam int TW = $clog2(TP_CYCLES + 1);
  localparam logic [3:0] C_KEY = 4'(KEY_BYTES);
  localparam logic [3:0] C_CMD = 4'(CMD_BYTES);
  localparam logic [3:0] C_MAX = 4'(CMD_BYTES + 1);

  lkd_state_e          state_q;
  logic [3:0]          cnt_q;
  logic                key_ok_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [TW-1:0]       tmr_q;
  logic                lock_set_q;
  logic [SEC_BITS-1:0] sec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      key_ok_q   <= 1'b0;
      addr_q     <= '0;
      tmr_q      <= '0;
      lock_set_q <= 1'b0;
      sec_q      <= '0;
    end else begin
      lock_set_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cs_fall) begin
            state_q  <= ST_COLLECT;
            cnt_q    <= '0;
            key_ok_q <= 1'b1;
          end
        end
        ST_COLLECT: begin
          if (cs_rise) begin
            if (key_ok_q && cnt_q == C_CMD && !partial) begin
              state_q <= ST_BUSY;
              tmr_q   <= TW'(TP_CYCLES - 1);
              sec_q   <= addr_q[SEC_LSB +: SEC_BITS];
            end else begin
              state_q <= ST_IDLE;
            end
          end else if (byte_vld) begin
            if (cnt_q < C_KEY && byte_i != key_byte(cnt_q)) key_ok_q <= 1'b0;
            addr_q <= {addr_q[ADDR_W-9:0], byte_i};
            if (cnt_q != C_MAX) cnt_q <= cnt_q + 4'd1;
          end
        end
        ST_BUSY: begin
          if (tmr_q == '0) begin
            state_q    <= ST_IDLE;
            lock_set_q <= 1'b1;
          end else begin
            tmr_q <= tmr_q - TW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q == ST_BUSY);
  assign lock_set = lock_set_q;
  assign lock_sec = sec_q;

  // Checker counter: length of the current busy run
  int run_q;
  always_ff @(posedge clk) begin
    if (rst)       run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_q == TP_CYCLES);

  // R1, R3
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(cnt_q) == C_CMD && $past(key_ok_q) && !$past(partial)));
endmodule

// File: rtl/lkd_lock_bank.sv
module lkd_lock_bank #(
  parameter int ADDR_W   = 24,
  parameter int SEC_LSB  = 16,
  parameter int SEC_BITS = 6
) (
  input  logic                      clk,
  input  logic                      pwr_on_clr,
  input  logic                      lock_set,
  input  logic [SEC_BITS-1:0]       lock_sec,
  input  logic [ADDR_W-1:0]         chk_addr,
  output logic [(1<<SEC_BITS)-1:0]  lock_vec,
  output logic                      write_permit
);
  localparam int NSEC = 1 << SEC_BITS;

  logic [NSEC-1:0] lock_q;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    always_ff @(posedge clk) begin
      if (pwr_on_clr)
        lock_q[s] <= 1'b0;
      else if (lock_set && lock_sec == SEC_BITS'(s))
        lock_q[s] <= 1'b1;
    end
  end

  logic unused_addr_bits;
  assign unused_addr_bits = ^chk_addr;

  assign lock_vec     = lock_q;
  assign write_permit = ~lock_q[chk_addr[SEC_LSB +: SEC_BITS]];

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (pwr_on_clr)
    !$past(pwr_on_clr) |-> ((lock_q & $past(lock_q)) == $past(lock_q)));

  // R7
  single_sector_chk: assert property (@(posedge clk) disable iff (pwr_on_clr)
    !$past(pwr_on_clr) |-> $countones(lock_q ^ $past(lock_q)) <= 1);
endmodule

// File: rtl/lockdown_unit.sv
module lockdown_unit #(
  parameter int ADDR_W    = 24,
  parameter int SEC_LSB   = 16,
  parameter int SEC_BITS  = 6,
  parameter int TP_CYCLES = 1000,
  parameter int SYNC      = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pwr_on_clr,
  input  logic                     spi_sck,
  input  logic                     spi_cs_n,
  input  logic                     spi_mosi,
  output logic                     busy,
  output logic [(1<<SEC_BITS)-1:0] lock_vec,
  input  logic [ADDR_W-1:0]        chk_addr,
  output logic                     write_permit
);
  logic                byte_vld, cs_fall, cs_rise, partial, lock_set;
  logic [7:0]          byte_w;
  logic [SEC_BITS-1:0] lock_sec;

  lkd_spi_front #(.SYNC(SYNC)) u_front (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .byte_vld(byte_vld), .byte_o(byte_w),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .partial(partial));

  lkd_cmd_fsm #(.ADDR_W(ADDR_W), .SEC_LSB(SEC_LSB), .SEC_BITS(SEC_BITS),
                .TP_CYCLES(TP_CYCLES)) u_fsm (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_i(byte_w),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .partial(partial),
    .busy(busy), .lock_set(lock_set), .lock_sec(lock_sec));

  lkd_lock_bank #(.ADDR_W(ADDR_W), .SEC_LSB(SEC_LSB), .SEC_BITS(SEC_BITS)) u_bank (
    .clk(clk), .pwr_on_clr(pwr_on_clr), .lock_set(lock_set),
    .lock_sec(lock_sec), .chk_addr(chk_addr), .lock_vec(lock_vec),
    .write_permit(write_permit));

  // R5
  lock_after_busy_chk: assert property (@(posedge clk) disable iff (rst || pwr_on_clr)
    (!$past(pwr_on_clr) && lock_vec != $past(lock_vec)) |-> (!$past(busy) && $past(busy, 2)));
endmodule

// File: tb/sim_lockdown_unit.sv
module sim_lockdown_unit;
  localparam int TP   = 1000;
  localparam int HALF = 4;
  localparam logic [31:0] KEY = 32'h3D2A7F30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_on_clr = 1'b1;
  logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        busy, write_permit;
  logic [63:0] lock_vec;
  logic [23:0] chk_addr = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [63:0] exp_lock = '0;

  always #10 clk = ~clk;

  lockdown_unit #(.TP_CYCLES(TP)) u0 (
    .clk(clk), .rst(rst), .pwr_on_clr(pwr_on_clr), .spi_sck(sck),
    .spi_cs_n(cs_n), .spi_mosi(mosi), .busy(busy), .lock_vec(lock_vec),
    .chk_addr(chk_addr), .write_permit(write_permit));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, cycles %0d expected below %0d", cyc, 190000);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int sec_of(input logic [23:0] a);
    return int'(a[21:16]);
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [63:0] v, input int n);
    cs_n = 1'b0; waitc(HALF);
    for (int i = 0; i < n; i++) begin
      mosi = v[63-i]; waitc(HALF);
      sck = 1'b1;     waitc(HALF);
      sck = 1'b0;
    end
    waitc(HALF); cs_n = 1'b1; waitc(1);
  endtask

  // wait up to 8 cycles for busy; returns 1 when seen
  task automatic wait_busy(output bit seen);
    seen = 0;
    for (int i = 0; i < 8 && !seen; i++) begin
      if (busy) seen = 1; else waitc(1);
    end
  endtask

  task automatic permit_probe(input logic [23:0] a, input string req);
    chk_addr = a; #1;
    check(write_permit == !exp_lock[sec_of(a)], req, 64'(write_permit), 64'(!exp_lock[sec_of(a)]));
  endtask

  task automatic do_cmd(input logic [31:0] key, input logic [23:0] addr, input int nbits, input string req);
    bit expect_ok, seen;
    int len;
    expect_ok = (key == KEY) && (nbits == 56);
    send_frame({key, addr, 8'hA5}, nbits);
    wait_busy(seen);
    check(seen == expect_ok, {req, " R4 busy start"}, 64'(seen), 64'(expect_ok));
    if (seen) begin
      len = 0;
      check(lock_vec == exp_lock, {req, " R5 no change at busy start"}, lock_vec, exp_lock);
      while (busy) begin len++; waitc(1); end
      check(len == TP, "R4 busy length", 64'(len), 64'(TP));
      check(lock_vec == exp_lock, "R5 bit not set before busy ends", lock_vec, exp_lock);
      waitc(1);
      exp_lock[sec_of(addr)] = 1'b1;
      check(lock_vec == exp_lock, {req, " R5 R7 bit set after busy"}, lock_vec, exp_lock);
    end else begin
      waitc(4);
      check(lock_vec == exp_lock, {req, " R3 no lock change"}, lock_vec, exp_lock);
    end
  endtask

  initial begin
    bit seen;
    logic [23:0] a;
    logic [31:0] k;
    int mode;
    void'($urandom(32'd20240917));

    waitc(5);
    rst = 1'b0; pwr_on_clr = 1'b0;
    waitc(2);
    // R11 reset state
    check(busy == 1'b0, "R11 busy after reset", 64'(busy), 64'd0);
    check(lock_vec == '0, "R11 lock_vec after power-on clear", lock_vec, '0);
    permit_probe(24'h123456, "R8 permit when nothing locked");

    // R1 R2 basic lock
    do_cmd(KEY, 24'h05_1234, 56, "R1 R2 sector 5");
    permit_probe(24'h05_FFFF, "R8 locked sector refused");
    permit_probe(24'h06_0000, "R8 neighbour permitted");
    // R2 upper bits ignored
    do_cmd(KEY, 24'hC7_ABCD, 56, "R2 sector 7 with bits 23:22 set");
    // R7 relock an already locked sector
    do_cmd(KEY, 24'h45_0000, 56, "R7 relock sector 5");

    // R1 each key byte corrupted
    for (int b = 0; b < 4; b++)
      do_cmd(KEY ^ (32'h01 << (8*b)), 24'h0A_0000, 56, "R1 bad key byte");
    // R3 wrong bit counts
    do_cmd(KEY, 24'h0B_0000, 55, "R3 one bit short");
    do_cmd(KEY, 24'h0B_0000, 57, "R3 one bit long");
    do_cmd(KEY, 24'h0B_0000, 64, "R3 one byte long");
    do_cmd(KEY, 24'h0B_0000, 32, "R3 key only");

    // R9 full command during busy is ignored
    send_frame({KEY, 24'h20_0000, 8'h00}, 56);
    wait_busy(seen);
    check(seen, "R9 first command busy", 64'(seen), 64'd1);
    send_frame({KEY, 24'h21_0000, 8'h00}, 56);
    check(busy == 1'b1, "R9 still busy after second frame", 64'(busy), 64'd1);
    while (busy) waitc(1);
    waitc(1);
    exp_lock[32] = 1'b1;
    waitc(8);
    check(busy == 1'b0, "R9 no second busy period", 64'(busy), 64'd0);
    check(lock_vec == exp_lock, "R9 only first sector locked", lock_vec, exp_lock);

    // R10 reset during busy
    send_frame({KEY, 24'h30_0000, 8'h00}, 56);
    wait_busy(seen);
    check(seen, "R10 command accepted", 64'(seen), 64'd1);
    waitc(20);
    rst = 1'b1; waitc(2); rst = 1'b0; waitc(1);
    check(busy == 1'b0, "R10 busy cleared by reset", 64'(busy), 64'd0);
    waitc(TP + 10);
    check(lock_vec == exp_lock, "R10 R6 bit unset, others kept after reset", lock_vec, exp_lock);

    // random mix
    for (int it = 0; it < 16; it++) begin
      a    = 24'($urandom);
      mode = int'($urandom % 4);
      k    = KEY;
      if (mode == 2) k = KEY ^ (32'(1 + $urandom % 255) << (8 * ($urandom % 4)));
      if (mode == 3) do_cmd(k, a, 56 + ((($urandom % 2) == 0) ? -1 : 1) * int'(1 + $urandom % 3), "R3 random length");
      else           do_cmd(k, a, 56, "R1 R2 random");
      permit_probe(24'($urandom), "R8 random probe");
      permit_probe(a, "R8 probe last address");
    end

    // R6 power-on clear
    pwr_on_clr = 1'b1; waitc(1); pwr_on_clr = 1'b0; waitc(1);
    exp_lock = '0;
    check(lock_vec == '0, "R6 R11 power-on clear", lock_vec, '0);
    permit_probe(24'h05_0000, "R8 permit after clear");

    summary();
  end
endmodule